// File: doc/BRIEF.md
# Banked CPU Register File

This block holds the architectural state of a small 16-bit processor core. It has four 16-bit data registers, two 24-bit pointer registers, 24-bit static-base, frame-base, program-counter and vector-table registers, two 24-bit stack pointers, and a 16-bit flag register. The data registers can also be reached as bytes or as 32-bit pairs. Bit 7 of the flag register chooses which stack pointer the generic stack identifier reaches.

For a high-speed interrupt there is a single-cycle context switch. An entry strobe copies the flags and program counter into dedicated save registers, loads the program counter from a jump register and moves execution onto the interrupt stack. A return strobe brings both saved values back in one cycle.

Access goes through two combinational read ports and one synchronous write port. Each port carries a register identifier and a size code. Instruction decode, the ALU and memory sit outside this block.

Top module: `cpu_rf`

## Requirements
- R1: After the active-low asynchronous reset is released, every register reads as zero.
- R2: Register ids are 0..3 for data registers D0..D3, 4/5 for pointers P0/P1, 6 static base, 7 frame base, 8 program counter, 9 vector table, 10 active stack, 11 user stack, 12 interrupt stack, 13 flags, 14 saved flags, 15 saved PC, and 16 jump register. Ids 17..31 read as zero. Size codes are 0 low byte, 1 high byte, 2 native width and 3 pair. A native write to a data register stores wdata[15:0], and a native read returns that value zero-extended to 32 bits.
- R3: Size codes 0 and 1 on D0 or D1 write or read only bits 7:0 or bits 15:8, and the other byte keeps its value. Byte-size writes to any other register have no effect.
- R4: A pair write to id 0 stores wdata[31:16] in D2 and wdata[15:0] in D0 in the same cycle. A pair write to id 1 does the same for D3 and D1. A pair read of id 0 or 1 returns {D2,D0} or {D3,D1}.
- R5: Native writes to the 24-bit registers keep only wdata[23:0], and reads of them are zero-extended.
- R6: Id 10 reaches the user stack when flag bit 7 is 1 and the interrupt stack when it is 0.
- R7: Every write to a stack pointer forces bit 0 to zero.
- R8: A read in the same cycle as a write to the same register returns the old value. The new value is visible after the clock edge.
- R9: On a fast-interrupt entry strobe, saved flags take the flags, saved PC takes the PC, the PC takes the jump register, and flag bit 7 is cleared, all at one edge.
- R10: In the cycle of an entry strobe, any write to the PC, flags, saved flags or saved PC is dropped, and a simultaneous return strobe is ignored.
- R11: A fast-return strobe without an entry strobe copies the saved flags into the flags and the saved PC into the PC at one edge, and a write to the PC or flags in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write enable |
| wid_i | input | 5 | Write register id |
| wsize_i | input | 2 | Write size code |
| wdata_i | input | 32 | Write data |
| ra_id_i | input | 5 | Read port A register id |
| ra_size_i | input | 2 | Read port A size code |
| ra_data_o | output | 32 | Read port A data |
| rb_id_i | input | 5 | Read port B register id |
| rb_size_i | input | 2 | Read port B size code |
| rb_data_o | output | 32 | Read port B data |
| fint_i | input | 1 | Fast-interrupt entry strobe |
| fret_i | input | 1 | Fast-interrupt return strobe |

## Verification
Every register can be read combinationally, so a corrupted value shows up on a read port in the cycle right after the bad edge. The exception is a register that the bench does not read back until later. A byte-lane or pair-routing fault shows up as a wrong neighbouring byte or half on the next read. A wrong stack-select polarity writes to the other stack, and this only becomes visible when both stacks are read back. A dropped or wrongly ordered context copy in the entry or return step shows up as a wrong PC, wrong flags or wrong save-register value one cycle after the strobe.

// File: rtl/cpu_rf_pkg.sv
package cpu_rf_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 24;
  localparam int U_BIT  = 7;
  localparam int ID_W   = 5;

  localparam logic [ID_W-1:0] RID_D0    = 5'd0;
  localparam logic [ID_W-1:0] RID_D1    = 5'd1;
  localparam logic [ID_W-1:0] RID_D2    = 5'd2;
  localparam logic [ID_W-1:0] RID_D3    = 5'd3;
  localparam logic [ID_W-1:0] RID_P0    = 5'd4;
  localparam logic [ID_W-1:0] RID_P1    = 5'd5;
  localparam logic [ID_W-1:0] RID_SBASE = 5'd6;
  localparam logic [ID_W-1:0] RID_FBASE = 5'd7;
  localparam logic [ID_W-1:0] RID_PC    = 5'd8;
  localparam logic [ID_W-1:0] RID_VTBL  = 5'd9;
  localparam logic [ID_W-1:0] RID_STK   = 5'd10;
  localparam logic [ID_W-1:0] RID_USTK  = 5'd11;
  localparam logic [ID_W-1:0] RID_ISTK  = 5'd12;
  localparam logic [ID_W-1:0] RID_FLAGS = 5'd13;
  localparam logic [ID_W-1:0] RID_SAVF  = 5'd14;
  localparam logic [ID_W-1:0] RID_SAVPC = 5'd15;
  localparam logic [ID_W-1:0] RID_JMP   = 5'd16;

  typedef enum logic [1:0] {
    SZ_LO   = 2'd0,
    SZ_HI   = 2'd1,
    SZ_NAT  = 2'd2,
    SZ_PAIR = 2'd3
  } size_e;
endpackage

// File: rtl/cpu_rf_data.sv
module cpu_rf_data
  import cpu_rf_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [ID_W-1:0]      wid_i,
  input  logic [1:0]           wsize_i,
  input  logic [2*DW-1:0]      wdata_i,
  output logic [3:0][DW-1:0]   d_o
);
  localparam int BW = DW / 2;

  logic [3:0][DW-1:0] d_q;
  logic [3:0][DW-1:0] d_nxt;

  for (genvar i = 0; i < 4; i++) begin : g_dreg
    if (i < 2) begin : g_low
      // byte-addressable, lower half of a pair
      always_comb begin
        d_nxt[i] = d_q[i];
        if (we_i && wid_i == ID_W'(i)) begin
          unique case (wsize_i)
            SZ_LO:   d_nxt[i][BW-1:0]  = wdata_i[BW-1:0];
            SZ_HI:   d_nxt[i][DW-1:BW] = wdata_i[BW-1:0];
            SZ_NAT:  d_nxt[i]          = wdata_i[DW-1:0];
            SZ_PAIR: d_nxt[i]          = wdata_i[DW-1:0];
            default: ;
          endcase
        end
      end
    end else begin : g_high
      // word-only, upper half of a pair
      always_comb begin
        d_nxt[i] = d_q[i];
        if (we_i && wid_i == ID_W'(i) && wsize_i == SZ_NAT)
          d_nxt[i] = wdata_i[DW-1:0];
        else if (we_i && wid_i == ID_W'(i-2) && wsize_i == SZ_PAIR)
          d_nxt[i] = wdata_i[2*DW-1:DW];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) d_q[i] <= '0;
      else         d_q[i] <= d_nxt[i];
    end
  end

  assign d_o = d_q;

  p_byte_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wid_i == RID_D0 && wsize_i == SZ_LO)
      |=> d_q[0][DW-1:BW] == $past(d_q[0][DW-1:BW]));

  p_pair_split_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wid_i == RID_D0 && wsize_i == SZ_PAIR)
      |=> {d_q[2], d_q[0]} == $past(wdata_i));
endmodule

// File: rtl/cpu_rf_addr.sv
module cpu_rf_addr
  import cpu_rf_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_nat_i,
  input  logic [ID_W-1:0]  wid_i,
  input  logic [AW-1:0]    wdata_i,
  input  logic             u_sel_i,
  output logic [4:0][AW-1:0] ptr_o,
  output logic [AW-1:0]    ustk_o,
  output logic [AW-1:0]    istk_o
);
  localparam int NP = 5;
  localparam logic [ID_W-1:0] PID [NP] = '{RID_P0, RID_P1, RID_SBASE, RID_FBASE, RID_VTBL};

  logic [NP-1:0][AW-1:0] ptr_q;
  logic [AW-1:0] ustk_q, istk_q;
  logic [AW-1:0] stk_wdata;
  logic ustk_we, istk_we;

  for (genvar i = 0; i < NP; i++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         ptr_q[i] <= '0;
      else if (we_nat_i && wid_i == PID[i]) ptr_q[i] <= wdata_i;
    end
  end

  assign stk_wdata = {wdata_i[AW-1:1], 1'b0};
  assign ustk_we   = we_nat_i && (wid_i == RID_USTK || (wid_i == RID_STK &&  u_sel_i));
  assign istk_we   = we_nat_i && (wid_i == RID_ISTK || (wid_i == RID_STK && !u_sel_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ustk_q <= '0;
      istk_q <= '0;
    end else begin
      if (ustk_we) ustk_q <= stk_wdata;
      if (istk_we) istk_q <= stk_wdata;
    end
  end

  assign ptr_o  = ptr_q;
  assign ustk_o = ustk_q;
  assign istk_o = istk_q;

  p_stk_even_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ustk_q[0] == 1'b0) && (istk_q[0] == 1'b0));

  p_stk_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_nat_i && wid_i == RID_STK && !u_sel_i) |=> $stable(ustk_q));
endmodule

// File: rtl/cpu_rf_ctx.sv
module cpu_rf_ctx
  import cpu_rf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int UB = U_BIT
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_nat_i,
  input  logic [ID_W-1:0] wid_i,
  input  logic [AW-1:0]   wdata_i,
  input  logic            fint_i,
  input  logic            fret_i,
  output logic [DW-1:0]   flg_o,
  output logic [AW-1:0]   pc_o,
  output logic [DW-1:0]   savf_o,
  output logic [AW-1:0]   savpc_o,
  output logic [AW-1:0]   jmp_o
);
  logic [DW-1:0] flg_q, savf_q, flg_d, savf_d;
  logic [AW-1:0] pc_q, savpc_q, jmp_q, pc_d, savpc_d, jmp_d;
  logic          ret_go;

  assign ret_go = fret_i && !fint_i;

  always_comb begin
    flg_d   = flg_q;
    pc_d    = pc_q;
    savf_d  = savf_q;
    savpc_d = savpc_q;
    jmp_d   = jmp_q;
    if (we_nat_i && wid_i == RID_JMP) jmp_d = wdata_i;
    if (fint_i) begin
      savf_d     = flg_q;
      savpc_d    = pc_q;
      pc_d       = jmp_q;
      flg_d[UB]  = 1'b0;
    end else begin
      if (we_nat_i && wid_i == RID_SAVF)  savf_d  = wdata_i[DW-1:0];
      if (we_nat_i && wid_i == RID_SAVPC) savpc_d = wdata_i;
      if (ret_go) begin
        flg_d = savf_q;
        pc_d  = savpc_q;
      end else begin
        if (we_nat_i && wid_i == RID_FLAGS) flg_d = wdata_i[DW-1:0];
        if (we_nat_i && wid_i == RID_PC)    pc_d  = wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q   <= '0;
      pc_q    <= '0;
      savf_q  <= '0;
      savpc_q <= '0;
      jmp_q   <= '0;
    end else begin
      flg_q   <= flg_d;
      pc_q    <= pc_d;
      savf_q  <= savf_d;
      savpc_q <= savpc_d;
      jmp_q   <= jmp_d;
    end
  end

  assign flg_o   = flg_q;
  assign pc_o    = pc_q;
  assign savf_o  = savf_q;
  assign savpc_o = savpc_q;
  assign jmp_o   = jmp_q;

  p_fint_save_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fint_i |=> (savf_q == $past(flg_q)) && (savpc_q == $past(pc_q))
               && (pc_q == $past(jmp_q)) && !flg_q[UB]);

  p_fint_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fint_i && we_nat_i && wid_i == RID_PC) |=> pc_q == $past(jmp_q));

  p_fret_restore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fret_i && !fint_i) |=> (flg_q == $past(savf_q)) && (pc_q == $past(savpc_q)));
endmodule

// File: rtl/cpu_rf.sv
module cpu_rf
  import cpu_rf_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int UB = U_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ID_W-1:0]   wid_i,
  input  logic [1:0]        wsize_i,
  input  logic [2*DW-1:0]   wdata_i,
  input  logic [ID_W-1:0]   ra_id_i,
  input  logic [1:0]        ra_size_i,
  output logic [2*DW-1:0]   ra_data_o,
  input  logic [ID_W-1:0]   rb_id_i,
  input  logic [1:0]        rb_size_i,
  output logic [2*DW-1:0]   rb_data_o,
  input  logic              fint_i,
  input  logic              fret_i
);
  localparam int XW = 2 * DW;
  localparam int BW = DW / 2;
  localparam int NRP = 2;

  logic [3:0][DW-1:0] d;
  logic [4:0][AW-1:0] ptr;
  logic [AW-1:0] ustk, istk, pc, savpc, jmp;
  logic [DW-1:0] flg, savf;
  logic we_nat;

  assign we_nat = we_i && wsize_i == SZ_NAT;

  cpu_rf_data #(.DW(DW)) u_data (
    .clk_i, .rst_ni, .we_i, .wid_i, .wsize_i, .wdata_i, .d_o(d)
  );

  cpu_rf_addr #(.AW(AW)) u_addr (
    .clk_i, .rst_ni, .we_nat_i(we_nat), .wid_i, .wdata_i(wdata_i[AW-1:0]),
    .u_sel_i(flg[UB]), .ptr_o(ptr), .ustk_o(ustk), .istk_o(istk)
  );

  cpu_rf_ctx #(.DW(DW), .AW(AW), .UB(UB)) u_ctx (
    .clk_i, .rst_ni, .we_nat_i(we_nat), .wid_i, .wdata_i(wdata_i[AW-1:0]),
    .fint_i, .fret_i, .flg_o(flg), .pc_o(pc), .savf_o(savf),
    .savpc_o(savpc), .jmp_o(jmp)
  );

  logic [NRP-1:0][ID_W-1:0] rid;
  logic [NRP-1:0][1:0]      rsz;
  logic [NRP-1:0][XW-1:0]   rdat;

  assign rid = {rb_id_i, ra_id_i};
  assign rsz = {rb_size_i, ra_size_i};

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    always_comb begin
      rdat[p] = '0;
      if (rid[p] == RID_D0 || rid[p] == RID_D1) begin
        unique case (rsz[p])
          SZ_LO:   rdat[p] = XW'(d[rid[p][0]][BW-1:0]);
          SZ_HI:   rdat[p] = XW'(d[rid[p][0]][DW-1:BW]);
          SZ_NAT:  rdat[p] = XW'(d[rid[p][0]]);
          SZ_PAIR: rdat[p] = {d[{1'b1, rid[p][0]}], d[rid[p][0]]};
          default: ;
        endcase
      end else if (rsz[p] == SZ_NAT) begin
        unique case (rid[p])
          RID_D2:    rdat[p] = XW'(d[2]);
          RID_D3:    rdat[p] = XW'(d[3]);
          RID_P0:    rdat[p] = XW'(ptr[0]);
          RID_P1:    rdat[p] = XW'(ptr[1]);
          RID_SBASE: rdat[p] = XW'(ptr[2]);
          RID_FBASE: rdat[p] = XW'(ptr[3]);
          RID_VTBL:  rdat[p] = XW'(ptr[4]);
          RID_PC:    rdat[p] = XW'(pc);
          RID_STK:   rdat[p] = XW'(flg[UB] ? ustk : istk);
          RID_USTK:  rdat[p] = XW'(ustk);
          RID_ISTK:  rdat[p] = XW'(istk);
          RID_FLAGS: rdat[p] = XW'(flg);
          RID_SAVF:  rdat[p] = XW'(savf);
          RID_SAVPC: rdat[p] = XW'(savpc);
          RID_JMP:   rdat[p] = XW'(jmp);
          default:   rdat[p] = '0;
        endcase
      end
    end
  end

  assign ra_data_o = rdat[0];
  assign rb_data_o = rdat[1];

  p_ret_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fint_i && fret_i) |=> pc == $past(jmp));
endmodule

// File: tb/cpu_rf_bench.sv
module cpu_rf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  wid = '0;
  logic [1:0]  wsz = '0;
  logic [31:0] wdat = '0;
  logic [4:0]  ra_id = '0, rb_id = '0;
  logic [1:0]  ra_sz = 2'd2, rb_sz = 2'd2;
  logic [31:0] ra_d, rb_d;
  logic        fint = 1'b0, fret = 1'b0;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  cpu_rf u_cpu_rf (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .wid_i(wid), .wsize_i(wsz),
    .wdata_i(wdat), .ra_id_i(ra_id), .ra_size_i(ra_sz), .ra_data_o(ra_d),
    .rb_id_i(rb_id), .rb_size_i(rb_sz), .rb_data_o(rb_d),
    .fint_i(fint), .fret_i(fret)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] id, input logic [1:0] sz, input logic [31:0] v);
    @(negedge clk);
    we = 1'b1; wid = id; wsz = sz; wdat = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] id, input logic [1:0] sz, input bit pb,
                    output logic [31:0] v);
    if (pb) begin rb_id = id; rb_sz = sz; #0.5 v = rb_d; end
    else    begin ra_id = id; ra_sz = sz; #0.5 v = ra_d; end
  endtask

  task automatic rchk(input string req, input logic [4:0] id, input logic [1:0] sz,
                      input logic [31:0] exp);
    logic [31:0] v;
    rd(id, sz, 1'b0, v); chk(req, v, exp);
    rd(id, sz, 1'b1, v); chk(req, v, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 20; i++) rchk("R1", 5'(i), 2'd2, 32'h0);
  endtask

  task automatic t_word;
    wr(5'd2, 2'd2, 32'h0000_1234);
    wr(5'd3, 2'd2, 32'h0000_BEEF);
    wr(5'd0, 2'd2, 32'hFFFF_5A5A);
    rchk("R2", 5'd2, 2'd2, 32'h1234);
    rchk("R2", 5'd3, 2'd2, 32'hBEEF);
    rchk("R2", 5'd0, 2'd2, 32'h5A5A);
  endtask

  task automatic t_byte;
    wr(5'd0, 2'd0, 32'h0000_00C3);
    rchk("R3", 5'd0, 2'd2, 32'h5AC3);
    wr(5'd0, 2'd1, 32'h0000_0077);
    rchk("R3", 5'd0, 2'd2, 32'h77C3);
    rchk("R3", 5'd0, 2'd0, 32'hC3);
    rchk("R3", 5'd0, 2'd1, 32'h77);
    wr(5'd2, 2'd0, 32'h0000_00FF);
    rchk("R3", 5'd2, 2'd2, 32'h1234);
    wr(5'd1, 2'd1, 32'h0000_00AB);
    rchk("R3", 5'd1, 2'd2, 32'hAB00);
  endtask

  task automatic t_pair;
    wr(5'd0, 2'd3, 32'hCAFE_F00D);
    rchk("R4", 5'd2, 2'd2, 32'hCAFE);
    rchk("R4", 5'd0, 2'd2, 32'hF00D);
    rchk("R4", 5'd0, 2'd3, 32'hCAFE_F00D);
    wr(5'd1, 2'd3, 32'h1111_2222);
    rchk("R4", 5'd3, 2'd2, 32'h1111);
    rchk("R4", 5'd1, 2'd3, 32'h1111_2222);
  endtask

  task automatic t_ptr;
    wr(5'd4, 2'd2, 32'hFF12_3456);
    rchk("R5", 5'd4, 2'd2, 32'h0012_3456);
    wr(5'd9, 2'd2, 32'h00AB_CDEF);
    rchk("R5", 5'd9, 2'd2, 32'h00AB_CDEF);
    wr(5'd5, 2'd0, 32'h0000_0055);
    rchk("R5", 5'd5, 2'd2, 32'h0);
  endtask

  task automatic t_stack;
    wr(5'd10, 2'd2, 32'h0000_0101);
    rchk("R6", 5'd12, 2'd2, 32'h0000_0100);
    rchk("R6", 5'd11, 2'd2, 32'h0);
    wr(5'd13, 2'd2, 32'h0000_0080);
    wr(5'd10, 2'd2, 32'h0000_2003);
    rchk("R6", 5'd11, 2'd2, 32'h0000_2002);
    rchk("R6", 5'd10, 2'd2, 32'h0000_2002);
    rchk("R6", 5'd12, 2'd2, 32'h0000_0100);
    wr(5'd12, 2'd2, 32'h0000_0007);
    rchk("R7", 5'd12, 2'd2, 32'h0000_0006);
  endtask

  task automatic t_rdw;
    logic [31:0] v;
    @(negedge clk);
    we = 1'b1; wid = 5'd1; wsz = 2'd2; wdat = 32'h0000_9999;
    rd(5'd1, 2'd2, 1'b0, v);
    chk("R8 old", v, 32'h2222);
    @(negedge clk);
    we = 1'b0;
    rd(5'd1, 2'd2, 1'b0, v);
    chk("R8 new", v, 32'h9999);
  endtask

  task automatic pulse(input bit e, input bit r);
    @(negedge clk);
    fint = e; fret = r;
    @(negedge clk);
    fint = 1'b0; fret = 1'b0;
  endtask

  task automatic t_fint;
    wr(5'd8, 2'd2, 32'h0000_0100);
    wr(5'd13, 2'd2, 32'h0000_0085);
    wr(5'd16, 2'd2, 32'h0000_ABCD);
    pulse(1'b1, 1'b0);
    rchk("R9", 5'd8, 2'd2, 32'h0000_ABCD);
    rchk("R9", 5'd15, 2'd2, 32'h0000_0100);
    rchk("R9", 5'd14, 2'd2, 32'h0000_0085);
    rchk("R9", 5'd13, 2'd2, 32'h0000_0005);
    rchk("R9", 5'd10, 2'd2, 32'h0000_0006);
  endtask

  task automatic t_fret;
    pulse(1'b0, 1'b1);
    rchk("R11", 5'd8, 2'd2, 32'h0000_0100);
    rchk("R11", 5'd13, 2'd2, 32'h0000_0085);
    rchk("R11", 5'd10, 2'd2, 32'h0000_2002);
  endtask

  task automatic t_prio;
    @(negedge clk);
    fint = 1'b1; we = 1'b1; wid = 5'd8; wsz = 2'd2; wdat = 32'h0055_5555;
    @(negedge clk);
    fint = 1'b0; we = 1'b0;
    rchk("R10", 5'd8, 2'd2, 32'h0000_ABCD);
    rchk("R10", 5'd15, 2'd2, 32'h0000_0100);
    @(negedge clk);
    fret = 1'b1; we = 1'b1; wid = 5'd13; wdat = 32'h0000_00FF;
    @(negedge clk);
    fret = 1'b0; we = 1'b0;
    rchk("R11", 5'd13, 2'd2, 32'h0000_0085);
    rchk("R11", 5'd8, 2'd2, 32'h0000_0100);
    wr(5'd8, 2'd2, 32'h0000_0200);
    pulse(1'b1, 1'b1);
    rchk("R10", 5'd8, 2'd2, 32'h0000_ABCD);
    rchk("R10", 5'd15, 2'd2, 32'h0000_0200);
    rchk("R10", 5'd13, 2'd2, 32'h0000_0005);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word();
    t_byte();
    t_pair();
    t_ptr();
    t_stack();
    t_rdw();
    t_fint();
    t_fret();
    t_prio();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule